// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a multi-channel successive-approximation converter. Software reaches it through four 32-bit words on a simple single-cycle bus. A write to the control word that sets the power bit and names a valid channel does three things: it powers the analog front end, it waits a programmable settling time, and it then searches for the input value one bit per clock. The search places a trial code on a DAC output and reads back one comparator input.

When the last bit is settled, the result is latched right-aligned in the data word and a completion flag is raised. An interrupt line follows that flag whenever software has enabled it. Writing zero to the control word powers the front end down and drops any sequence in progress. Writing the control word again with the power bit set restarts the sequence from the beginning with the newly selected channel.

Top module: `sar_seq_top`

## Requirements
- R1: After reset all four words read 0, `irq` is 0 and `adc_pwr` is 0.
- R2: Word index 0 is the result, 1 the status, 2 the control and 3 the settling delay. The delay word keeps the low DLY_W bits written to it and reads zero above them.
- R3: A control write with bit 3 = 1 and a channel below NUM_CH in bits [2:0] drives `adc_pwr` high and `adc_chan` to that channel. Afterwards the control word reads back the channel in [2:0], power in bit 3 and the interrupt enable in bit 5.
- R4: With delay value D, completion (bit 6) is reached exactly D+1+RES_W clock edges after the edge that takes the start write. Status bit 0 reads 1 from the start until completion and 0 otherwise.
- R5: The search works from the MSB down to the LSB and keeps each trial bit when `cmp_in` is 1, which means the input is at or above the trial code. The result is the input value, right-aligned in the data word, with the upper bits reading 0.
- R6: Control bit 6 becomes 1 when the result is valid and returns to 0 when a new start is taken.
- R7: `irq` is 1 exactly while control bits 5 and 6 are both 1. With bit 5 clear, completion leaves `irq` at 0.
- R8: A control write with bit 3 = 0 lowers `adc_pwr` and ends any sequence. Afterwards control and status read 0, no completion follows, and the data word keeps the last result.
- R9: A start write during a sequence restarts it from the settling delay with the new channel, and the R4 timing is counted from the rewrite.
- R10: A start write whose channel is at or above NUM_CH is ignored: power, channel and all control bits stay as they were.
- R11: Writes to the data and status words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Completion interrupt |
| adc_pwr | output | 1 | Analog front-end power enable |
| adc_chan | output | 3 | Selected analog channel |
| dac_code | output | RES_W | Trial code to the DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |

## Verification
The assertions assume that `cmp_in` is a function of the current `dac_code` and the analog input. They also assume that bus accesses last a single strobed cycle. The bench holds to both. Its comparator model is a combinational compare of `dac_code` against a target that changes only while no search is running or just before a restart. Its bus tasks raise `bus_sel` for exactly one cycle, between falling edges.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_SEARCH} sar_state_e;

  localparam logic [1:0] W_RESULT = 2'd0;
  localparam logic [1:0] W_STATUS = 2'd1;
  localparam logic [1:0] W_CTRL   = 2'd2;
  localparam logic [1:0] W_DELAY  = 2'd3;

  localparam int CB_PWR  = 3;
  localparam int CB_IEN  = 5;
  localparam int CB_DONE = 6;
  localparam int CH_W    = 3;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 3,
  parameter int DLY_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [RES_W-1:0] result,
  input  logic             busy,
  input  logic             done,
  output logic [DLY_W-1:0] dly_q,
  output logic [CH_W-1:0]  ch_q,
  output logic             ien_q,
  output logic             pwr_q,
  output logic             start,
  output logic             stop
);
  localparam logic [31:0] NCH = NUM_CH;

  logic wr_ctrl, ch_ok;
  logic [31:0] rd_mux;

  always_comb begin
    wr_ctrl = bus_sel && bus_wr && (bus_addr == W_CTRL);
    ch_ok   = {29'd0, bus_wdata[CH_W-1:0]} < NCH;
    start   = wr_ctrl && bus_wdata[CB_PWR] && ch_ok;
    stop    = wr_ctrl && !bus_wdata[CB_PWR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q  <= '0;
      ien_q <= 1'b0;
      pwr_q <= 1'b0;
      dly_q <= '0;
    end else begin
      if (start) begin
        ch_q  <= bus_wdata[CH_W-1:0];
        ien_q <= bus_wdata[CB_IEN];
        pwr_q <= 1'b1;
      end else if (stop) begin
        ch_q  <= '0;
        ien_q <= 1'b0;
        pwr_q <= 1'b0;
      end
      if (bus_sel && bus_wr && bus_addr == W_DELAY)
        dly_q <= bus_wdata[DLY_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      W_RESULT: rd_mux[RES_W-1:0] = result;
      W_STATUS: rd_mux[0] = busy;
      W_CTRL: begin
        rd_mux[CH_W-1:0] = ch_q;
        rd_mux[CB_PWR]   = pwr_q;
        rd_mux[CB_IEN]   = ien_q;
        rd_mux[CB_DONE]  = done;
      end
      default: rd_mux[DLY_W-1:0] = dly_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [DLY_W-1:0] dly,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [RES_W-1:0] dac_code
);
  localparam int IW = $clog2(RES_W);
  localparam logic [IW-1:0]    TOP_IDX = IW'(RES_W - 1);
  localparam logic [RES_W-1:0] ONE     = RES_W'(1);
  localparam logic [RES_W-1:0] MSB_SET = ONE << (RES_W - 1);

  sar_state_e       st_q;
  logic [DLY_W-1:0] cnt_q;
  logic [IW-1:0]    idx_q;
  logic [RES_W-1:0] cur_msk, nxt_msk, kept;

  always_comb begin
    cur_msk = ONE << idx_q;
    nxt_msk = cur_msk >> 1;
    kept    = cmp_in ? dac_code : (dac_code & ~cur_msk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      dac_code <= '0;
      result   <= '0;
      done     <= 1'b0;
    end else if (stop) begin
      st_q     <= ST_IDLE;
      dac_code <= '0;
      done     <= 1'b0;
    end else if (start) begin
      st_q     <= ST_SETTLE;
      cnt_q    <= dly;
      dac_code <= '0;
      done     <= 1'b0;
    end else begin
      case (st_q)
        ST_SETTLE: begin
          if (cnt_q == '0) begin
            st_q     <= ST_SEARCH;
            idx_q    <= TOP_IDX;
            dac_code <= MSB_SET;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_SEARCH: begin
          if (idx_q == '0) begin
            result   <= kept;
            dac_code <= kept;
            done     <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            dac_code <= kept | nxt_msk;
            idx_q    <= idx_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 3,
  parameter int DLY_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             adc_pwr,
  output logic [2:0]       adc_chan,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in
);
  logic [DLY_W-1:0] dly_w;
  logic [RES_W-1:0] result_w;
  logic busy_w, done_w, ien_w, start_w, stop_w;

  sar_regs #(.RES_W(RES_W), .NUM_CH(NUM_CH), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .result(result_w), .busy(busy_w), .done(done_w), .dly_q(dly_w),
    .ch_q(adc_chan), .ien_q(ien_w), .pwr_q(adc_pwr),
    .start(start_w), .stop(stop_w)
  );

  sar_fsm #(.RES_W(RES_W), .DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start_w), .stop(stop_w), .dly(dly_w),
    .cmp_in(cmp_in), .busy(busy_w), .done(done_w), .result(result_w),
    .dac_code(dac_code)
  );

  assign irq = ien_w & done_w;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             adc_pwr,
  input logic [2:0]       adc_chan,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result
);
  localparam logic [31:0] NCH = NUM_CH;

  assert_chan_valid_R10: assert property (@(posedge clk) disable iff (rst)
    adc_pwr |-> ({29'd0, adc_chan} < NCH));

  assert_busy_powered_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> adc_pwr);

  assert_irq_powered_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> adc_pwr);

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> ($past(busy) && done));
endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .adc_pwr(adc_pwr), .adc_chan(adc_chan),
  .busy(busy_w), .done(done_w), .result(result_w)
);

// File: tb/test_sar_seq_top.sv
`timescale 1ns/1ps
module test_sar_seq_top;
  localparam int RES_W = 10;
  localparam int NUM_CH = 3;
  localparam int NV = 6;
  // each entry: channel[31:24], delay[23:16], target[15:0]
  localparam logic [31:0] VEC [NV] = '{
    32'h0008_02A5, 32'h0100_0000, 32'h0203_03FF,
    32'h0101_0200, 32'h0005_01FF, 32'h0208_0155
  };

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, adc_pwr, cmp_in;
  logic [2:0] adc_chan;
  logic [RES_W-1:0] dac_code, target = 0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;
  assign cmp_in = (target >= dac_code);

  sar_seq_top #(.RES_W(RES_W), .NUM_CH(NUM_CH), .DLY_W(16)) i_sar_seq_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .adc_pwr(adc_pwr), .adc_chan(adc_chan),
    .dac_code(dac_code), .cmp_in(cmp_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  // start and check the exact completion edge (ien set)
  task automatic conv(input string req, input int ch, input int d, input logic [RES_W-1:0] t);
    target = t;
    bwr(2'd3, 32'(d));
    bwr(2'd2, 32'h28 | 32'(ch));
    for (int k = 1; k <= d + 1 + RES_W; k++) begin
      @(negedge clk);
      if (k == 1) chk({req, " R3 chan"}, {29'd0, adc_chan}, 32'(ch));
      if (k == d + RES_W) chk({req, " R4 early"}, {31'd0, irq}, 0);
      if (k == d + 1 + RES_W) chk({req, " R4 on time"}, {31'd0, irq}, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pwr", {31'd0, adc_pwr}, 0);
    for (int a = 0; a < 4; a++) begin
      brd(2'(a), rd); chk("R1 word", rd, 0);
    end
    // R2 delay word width
    bwr(2'd3, 32'h1234_00AB); brd(2'd3, rd); chk("R2 delay", rd, 32'h0000_00AB);

    // table walk: R3 R4 R5 R6 R7, then R8 stop
    for (int i = 0; i < NV; i++) begin
      conv("vec", int'(VEC[i][31:24]), int'(VEC[i][23:16]), VEC[i][RES_W-1:0]);
      brd(2'd0, rd); chk("R5 result", rd, {22'd0, VEC[i][RES_W-1:0]});
      brd(2'd2, rd); chk("R3 R6 ctrl", rd, 32'h68 | {29'd0, VEC[i][26:24]});
      brd(2'd1, rd); chk("R4 idle status", rd, 0);
      bwr(2'd2, 0);
      chk("R8 pwr off", {31'd0, adc_pwr}, 0);
      chk("R7 irq off", {31'd0, irq}, 0);
      brd(2'd0, rd); chk("R8 data kept", rd, {22'd0, VEC[i][RES_W-1:0]});
    end

    // R4 busy status during settle
    target = 10'h123;
    bwr(2'd3, 8); bwr(2'd2, 32'h29);
    brd(2'd1, rd); chk("R4 busy", rd, 1);
    repeat (25) @(negedge clk);
    brd(2'd1, rd); chk("R4 not busy", rd, 0);
    brd(2'd2, rd); chk("R6 done", rd, 32'h69);
    // R6 new start clears bit 6
    bwr(2'd2, 32'h2A); brd(2'd2, rd); chk("R6 cleared", rd, 32'h2A);

    // R8 abort mid-search
    repeat (12) @(negedge clk);
    bwr(2'd2, 0);
    brd(2'd1, rd); chk("R8 status", rd, 0);
    repeat (30) @(negedge clk);
    chk("R8 no irq", {31'd0, irq}, 0);
    brd(2'd2, rd); chk("R8 ctrl", rd, 0);
    brd(2'd0, rd); chk("R8 old result", rd, 32'h123);

    // R9 restart during search
    target = 10'h0F0;
    bwr(2'd3, 4); bwr(2'd2, 32'h28);
    repeat (6) @(negedge clk);
    conv("R9 restart", 2, 4, 10'h30C);
    brd(2'd0, rd); chk("R9 result", rd, 32'h30C);
    chk("R9 chan", {29'd0, adc_chan}, 2);

    // R10 invalid channel ignored while powered
    bwr(2'd2, 32'h2F);
    chk("R10 pwr kept", {31'd0, adc_pwr}, 1);
    chk("R10 chan kept", {29'd0, adc_chan}, 2);
    brd(2'd2, rd); chk("R10 ctrl kept", rd, 32'h6A);
    bwr(2'd2, 0);
    bwr(2'd2, 32'h2B);
    repeat (30) @(negedge clk);
    chk("R10 stays off", {31'd0, adc_pwr}, 0);
    brd(2'd1, rd); chk("R10 not busy", rd, 0);

    // R11 read-only words
    bwr(2'd0, 32'hFFFF_FFFF); bwr(2'd1, 32'hFFFF_FFFF);
    brd(2'd0, rd); chk("R11 data", rd, 32'h30C);
    brd(2'd1, rd); chk("R11 status", rd, 0);

    // R7 interrupt disabled
    target = 10'h077;
    bwr(2'd3, 2); bwr(2'd2, 32'h09);
    repeat (30) @(negedge clk);
    chk("R7 no irq", {31'd0, irq}, 0);
    brd(2'd2, rd); chk("R7 ctrl", rd, 32'h49);
    brd(2'd0, rd); chk("R5 result", rd, 32'h077);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule